// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

This block sits between two parallel data buses, A and B, and moves words between them in either direction or both at once, without inverting any bit. Each bus is presented as a separate input word, output word and output-enable bit, so the tri-state pad or a resolution net outside the block combines them. Each direction owns one storage register. The A-side register samples bus A and the B-side register samples bus B, each on its own capture strobe. A capture does not depend on the select or enable inputs.

Per direction, a source select chooses the word offered to the opposite bus: the live word from the other bus, or the word held in that direction's register. The A-to-B enable is active high. The B-to-A enable is active low. When a direction is disabled, its output word is forced to zero and its enable bit is low.

Two modes use both buses at once. With both directions live and both enabled, each bus drives back what it receives, so a pair of released buses keeps its value with no register involved. With both directions on stored data and both enabled, the two stored words cross in the same cycle.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to zero. After reset, a direction that selects stored data and is enabled outputs zero.
- R2: On a rising clock edge with `cap_a` high, the A-side register loads `a_in`, whatever the select and enable inputs are.
- R3: On a rising clock edge with `cap_b` high, the B-side register loads `b_in`, whatever the select and enable inputs are.
- R4: With `en_ab` = 1 and `sel_ab` = 0 (live), `b_out` equals `a_in` in the same cycle.
- R5: With `en_ab` = 1 and `sel_ab` = 1 (stored), `b_out` equals the A-side register and ignores `a_in`.
- R6: With `en_ba_n` = 0, `a_out` equals `b_in` when `sel_ba` = 0 and equals the B-side register when `sel_ba` = 1.
- R7: With `en_ab` = 0, `b_oe` is 0 and `b_out` is all zeros. `b_oe` is 1 whenever `en_ab` is 1.
- R8: With `en_ba_n` = 1, `a_oe` is 0 and `a_out` is all zeros. `a_oe` is 1 whenever `en_ba_n` is 0.
- R9: With both selects at 1 and both directions enabled, the stored A word appears on `b_out` and the stored B word appears on `a_out` in the same cycle.
- R10: A register whose capture strobe is low keeps its value across clock edges.
- R11: Both capture strobes may be high in the same cycle. Each register then loads its own bus.
- R12: With both selects at 0 and both directions enabled, a word placed on one bus by an external driver keeps both buses at that word after the external driver is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; captures occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset of both registers |
| a_in | input | WIDTH | Word currently seen on bus A |
| b_in | input | WIDTH | Word currently seen on bus B |
| cap_a | input | 1 | Capture strobe for the A-side register |
| cap_b | input | 1 | Capture strobe for the B-side register |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| en_ab | input | 1 | A-to-B enable, active high |
| en_ba_n | input | 1 | B-to-A enable, active low |
| a_out | output | WIDTH | Word to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | WIDTH | Word to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench builds the block with WIDTH = 4. At that width every pair of stored words can be loaded, and each pair is then observed under all sixteen combinations of the two selects and two enables, with fresh live words on both inputs. Captures are made with the control inputs in scattered states, including both directions disabled, so the bench shows that capture does not depend on them. Both bus directions are resolved in the bench from the block's output word and enable together with an external driver, which reaches the mutual-hold mode and the crossing of both stored words.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;
  localparam int N_DIR  = 2;
endpackage

// File: rtl/bxr_store.sv
module bxr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

  // R1: reset leaves the register cleared
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> q == '0);
  // R2 and R3 share this register: a strobe loads the sampled word
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    cap |=> q == $past(d));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q));
endmodule

// File: rtl/bxr_path.sv
module bxr_path
  import bxr_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter bit ACTIVE_LOW_EN = 1'b0
) (
  input  logic             en_pin,
  input  logic             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out,
  output logic             oe
);
  logic             en;
  logic [WIDTH-1:0] pick;

  generate
    if (ACTIVE_LOW_EN) begin : g_low
      assign en = ~en_pin;
    end else begin : g_high
      assign en = en_pin;
    end
  endgenerate

  always_comb begin
    pick = (src_sel_e'(sel) == SRC_STORED) ? stored : live;
    out  = en ? pick : '0;
    oe   = en;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bxr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             en_ab,
  input  logic             en_ba_n,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] src_w  [N_DIR];
  logic [WIDTH-1:0] held_w [N_DIR];
  logic [WIDTH-1:0] dst_w  [N_DIR];
  logic             cap_v  [N_DIR];
  logic             sel_v  [N_DIR];
  logic             en_v   [N_DIR];
  logic             oe_v   [N_DIR];

  assign src_w[DIR_AB] = a_in;
  assign src_w[DIR_BA] = b_in;
  assign cap_v[DIR_AB] = cap_a;
  assign cap_v[DIR_BA] = cap_b;
  assign sel_v[DIR_AB] = sel_ab;
  assign sel_v[DIR_BA] = sel_ba;
  assign en_v[DIR_AB]  = en_ab;
  assign en_v[DIR_BA]  = en_ba_n;

  generate
    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
      bxr_store #(.WIDTH(WIDTH)) store_i (
        .clk (clk),
        .rst (rst),
        .cap (cap_v[g]),
        .d   (src_w[g]),
        .q   (held_w[g])
      );
      bxr_path #(.WIDTH(WIDTH), .ACTIVE_LOW_EN(g == DIR_BA)) path_i (
        .en_pin (en_v[g]),
        .sel    (sel_v[g]),
        .live   (src_w[g]),
        .stored (held_w[g]),
        .out    (dst_w[g]),
        .oe     (oe_v[g])
      );
    end
  endgenerate

  assign b_out = dst_w[DIR_AB];
  assign b_oe  = oe_v[DIR_AB];
  assign a_out = dst_w[DIR_BA];
  assign a_oe  = oe_v[DIR_BA];

  p_b_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en_ab |-> (!b_oe && b_out == '0));
  p_a_off_r8: assert property (@(posedge clk) disable iff (rst)
    en_ba_n |-> (!a_oe && a_out == '0));
  p_b_live_r4: assert property (@(posedge clk) disable iff (rst)
    (en_ab && !sel_ab) |-> b_out == a_in);
  p_a_live_r6: assert property (@(posedge clk) disable iff (rst)
    (!en_ba_n && !sel_ba) |-> a_out == b_in);
  p_b_stored_r5: assert property (@(posedge clk) disable iff (rst)
    (en_ab && sel_ab && !cap_a) |=> (!(en_ab && sel_ab) || b_out == $past(b_out)));
  p_cross_r9: assert property (@(posedge clk) disable iff (rst)
    (en_ab && sel_ab && !en_ba_n && sel_ba && !cap_a && !cap_b) |=>
    (!(en_ab && sel_ab && !en_ba_n && sel_ba) ||
     (b_out == $past(b_out) && a_out == $past(a_out))));
endmodule

// File: tb/bus_xcvr_reg_tb_top.sv
`timescale 1ns/100ps
module bus_xcvr_reg_tb_top;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         cap_a = 1'b0, cap_b = 1'b0;
  logic         sel_ab = 1'b0, sel_ba = 1'b0, en_ab = 1'b0, en_ba_n = 1'b1;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W-1:0] ref_a = '0, ref_b = '0;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic         ext_a_en = 1'b0, ext_b_en = 1'b0;
  logic [W-1:0] bus_a = '0, bus_b = '0;

  always #2.5 clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .cap_a(cap_a), .cap_b(cap_b), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Resolves both buses: external driver wins, else the block, else zero.
  task automatic settle();
    for (int k = 0; k < 4; k++) begin
      bus_a = ext_a_en ? ext_a : (a_oe ? a_out : '0);
      bus_b = ext_b_en ? ext_b : (b_oe ? b_out : '0);
      a_in  = bus_a;
      b_in  = bus_b;
      #0.2;
    end
  endtask

  task automatic set_ctrl(logic [3:0] c);
    sel_ab = c[0]; sel_ba = c[1]; en_ab = c[2]; en_ba_n = c[3];
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state seen through the stored paths
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    a_in = 4'hF; b_in = 4'hF;
    set_ctrl(4'b0111);
    #1;
    chk("R1 b_out stored after reset", b_out, '0);
    chk("R1 a_out stored after reset", a_out, '0);

    // Near-exhaustive sweep of stored pairs, live words and controls
    for (int sa = 0; sa < N; sa++) begin
      for (int sb = 0; sb < N; sb++) begin
        @(negedge clk);
        a_in = W'(sa); b_in = W'(sb);
        cap_a = 1'b1; cap_b = 1'b1;   // R11: both strobes together
        set_ctrl(4'((sa + sb) % 16)); // R2 R3: capture under any control state
        @(posedge clk);
        ref_a = W'(sa); ref_b = W'(sb);
        @(negedge clk);
        cap_a = 1'b0; cap_b = 1'b0;
        a_in = ~W'(sa); b_in = W'(sb + 3);
        for (int c = 0; c < 16; c++) begin
          logic [W-1:0] eb, ea;
          set_ctrl(4'(c));
          #0.1;
          eb = en_ab ? (sel_ab ? ref_a : a_in) : '0;
          ea = !en_ba_n ? (sel_ba ? ref_b : b_in) : '0;
          chk(!en_ab ? "R7 b_out off" : (sel_ab ? "R5 b_out stored (R2)" : "R4 b_out live"),
              b_out, eb);
          chk(en_ba_n ? "R8 a_out off" : "R6 a_out select (R3)", a_out, ea);
          chk("R7 b_oe", W'(b_oe), W'(en_ab));
          chk("R8 a_oe", W'(a_oe), W'(!en_ba_n));
        end
      end
    end

    // R10: strobe low across edges, new words on inputs
    @(negedge clk);
    a_in = 4'h6; b_in = 4'h9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    set_ctrl(4'b0111);
    #0.1;
    chk("R10 A register held", b_out, ref_a);
    chk("R10 B register held", a_out, ref_b);

    // R2 R3: load each side on its own while both outputs are disabled
    @(negedge clk);
    set_ctrl(4'b1000);
    a_in = 4'h3; b_in = 4'h5; cap_a = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cap_a = 1'b0; a_in = 4'hE; b_in = 4'hC; cap_b = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cap_b = 1'b0;
    chk("R7 disabled during capture", b_out, '0);
    chk("R8 disabled during capture", a_out, '0);

    // R9: both stored words cross at once on resolved buses
    ext_a_en = 1'b0; ext_b_en = 1'b0;
    set_ctrl(4'b0111);
    settle();
    chk("R9 bus B holds stored A", bus_b, 4'h3);
    chk("R9 bus A holds stored B", bus_a, 4'hC);

    // R12: mutual hold with live paths
    @(negedge clk);
    set_ctrl(4'b0100);
    ext_a = 4'hA; ext_a_en = 1'b1;
    settle();
    chk("R12 bus B follows driven A", bus_b, 4'hA);
    ext_a_en = 1'b0;
    settle();
    chk("R12 bus A held after release", bus_a, 4'hA);
    chk("R12 bus B held after release", bus_b, 4'hA);
    ext_b = 4'h5; ext_b_en = 1'b1;
    settle();
    chk("R12 bus A follows driven B", bus_a, 4'h5);
    ext_b_en = 1'b0;
    settle();
    chk("R12 bus A held on B release", bus_a, 4'h5);
    en_ab = 1'b0; en_ba_n = 1'b1;
    settle();
    chk("R12 hold lost when disabled", bus_a, '0);

    // R1: reset again clears both registers
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    set_ctrl(4'b0111);
    #0.1;
    chk("R1 A register cleared", b_out, '0);
    chk("R1 B register cleared", a_out, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule